// File: doc/BRIEF.md
# Short-Frame Suppression Filter

This block sits in the receive path of a proximity-card reader, between the byte assembler and the receive FIFO. It holds back the opening bytes of every frame until it knows how the frame ends or how long it is. A frame that ends with fewer than three data bytes and that saw at least one reception error is treated as electromagnetic disturbance and not as a card reply. Nothing of such a frame reaches the FIFO, and a one-cycle pulse reports the discard.

Frames of three or more bytes are always committed. Once the third byte arrives, the held bytes are replayed to the FIFO in arrival order and the rest of the frame streams through directly. Filtering is active only when the enable input is high and the protocol input selects type A or type B. The controlling enable bit is held elsewhere and clears to 0 at reset. In every other configuration the block is a plain wire with handshake. When the FIFO is not ready during a replay, the input side is stalled.

Input beats are accepted when `in_valid_i && in_ready_o`. A beat carries either one data byte or, with `in_eof_i` high, an end-of-frame marker. FIFO writes happen when `out_valid_o && out_ready_i`. A write with `out_eof_o` high is the end marker.

Top module: `rx_short_frame_filter`

## Requirements
- R1: After reset, with `out_ready_i` high and no input, `out_valid_o` and `drop_o` are 0 and `in_ready_o` is 1.
- R2: Filtering applies only when `en_i`=1 and `proto_i` is 0 (type A) or 1 (type B); codes 2 and 3 are other modes. Otherwise every beat, errors included, is forwarded in the same cycle, with `in_ready_o` equal to `out_ready_i`.
- R3: In a filtered frame that ends with 0, 1 or 2 data bytes, where `in_err_i` was high on any of its beats (the end beat included), the block makes no FIFO write, end marker included. `drop_o` is high for exactly the cycle of the end beat.
- R4: A filtered frame of 1 or 2 bytes with no error is written out as its bytes in arrival order, followed by one end marker.
- R5: In a filtered frame there is no FIFO write before the third byte or the end beat has been accepted. The held bytes are then written in arrival order, first byte first.
- R6: After the third byte of a filtered frame, later bytes pass straight through. Errors on the third or later bytes, or on the end beat of such a frame, neither suppress the frame nor raise `drop_o`.
- R7: While `out_valid_o` is high and `out_ready_i` low, `in_ready_o` is 0. During a replay, the output data and marker stay stable until accepted.
- R8: On an end-marker write, `out_data_o` is 0, and the data input of an end beat is ignored.
- R9: A filtered frame with no data bytes yields a single end-marker write when error-free, and is dropped with a `drop_o` pulse when its end beat carries an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Suppression enable |
| proto_i | input | 2 | Protocol: 0 type A, 1 type B, 2/3 other |
| in_valid_i | input | 1 | Input beat valid |
| in_data_i | input | DW | Received byte |
| in_err_i | input | 1 | Reception error flagged on this beat |
| in_eof_i | input | 1 | Beat is an end-of-frame marker |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| out_valid_o | output | 1 | FIFO write request |
| out_data_o | output | DW | FIFO write data |
| out_eof_o | output | 1 | Write is the end-of-frame marker |
| out_ready_i | input | 1 | FIFO can accept a write |
| drop_o | output | 1 | One-cycle pulse: frame discarded |

## Verification
The bench sweeps every combination of enable, all four protocol codes, and frame lengths 0 to 5. For each frame it tries no error, an error on each byte position in turn, and an error on the end beat. This separates the drop rule from the length threshold: the same error on byte two drops a two-byte frame but not a three-byte one, and an error-free short frame must still arrive whole. Each frame also runs under one of three FIFO ready patterns (always ready, alternating, one in three), which exposes replay ordering, held data during stalls, and input stalling. A monitor flags any write made before the third byte or the end beat of a filtered frame.

// File: rtl/sff_pkg.sv
`timescale 1ns/1ps
package sff_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_PASS  = 2'd2
  } sff_state_e;

  typedef logic [1:0] sff_proto_t;
  localparam sff_proto_t PROTO_TYPE_A = 2'd0;
  localparam sff_proto_t PROTO_TYPE_B = 2'd1;

  function automatic logic proto_filtered(sff_proto_t p);
    return (p == PROTO_TYPE_A) || (p == PROTO_TYPE_B);
  endfunction
endpackage

// File: rtl/sff_hold_buf.sv
`timescale 1ns/1ps
module sff_hold_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (wr_en_i && (wr_idx_i == IW'(g)))   q <= wr_data_i;
    end
    assign ent[g] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (rd_idx_i == IW'(k)) rd_data_o = ent[k];
  end
endmodule

// File: rtl/sff_ctrl.sv
`timescale 1ns/1ps
module sff_ctrl
  import sff_pkg::*;
#(
  parameter int HOLD_N = 2,
  localparam int DEPTH = HOLD_N + 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  sff_proto_t    proto_i,
  input  logic          in_valid_i,
  input  logic          in_err_i,
  input  logic          in_eof_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic          out_eof_o,
  input  logic          out_ready_i,
  output logic          drop_o,
  output logic          use_in_o,
  output logic          buf_we_o,
  output logic [IW-1:0] buf_widx_o,
  output logic [IW-1:0] buf_ridx_o,
  output sff_state_e    st_o,
  output logic [CW-1:0] cnt_o
);
  sff_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, rd_q, rd_d;
  logic          err_q, err_d, peof_q, peof_d;
  logic          filt, bypass;

  assign filt   = en_i && proto_filtered(proto_i);
  // pass-through: committed frame, or idle with filtering off
  assign bypass = (st_q == ST_PASS) || ((st_q == ST_HOLD) && (cnt_q == '0) && !filt);

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    rd_d        = rd_q;
    err_d       = err_q;
    peof_d      = peof_q;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_eof_o   = 1'b0;
    drop_o      = 1'b0;
    buf_we_o    = 1'b0;
    use_in_o    = bypass;
    if (bypass) begin
      in_ready_o  = out_ready_i;
      out_valid_o = in_valid_i;
      out_eof_o   = in_eof_i;
      if (in_valid_i && out_ready_i) st_d = in_eof_i ? ST_HOLD : ST_PASS;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          in_ready_o = 1'b1;
          if (in_valid_i) begin
            if (!in_eof_i) begin
              buf_we_o = 1'b1;
              cnt_d    = cnt_q + 1'b1;
              err_d    = err_q | in_err_i;
              if (cnt_q == CW'(HOLD_N)) begin
                st_d   = ST_FLUSH;
                rd_d   = '0;
                peof_d = 1'b0;
              end
            end else if (err_q || in_err_i) begin
              drop_o = 1'b1;
              cnt_d  = '0;
              err_d  = 1'b0;
            end else begin
              st_d   = ST_FLUSH;
              rd_d   = '0;
              peof_d = 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          out_valid_o = 1'b1;
          if (rd_q < cnt_q) begin
            if (out_ready_i) begin
              rd_d = rd_q + 1'b1;
              if ((rd_q + 1'b1 == cnt_q) && !peof_q) begin
                st_d  = ST_PASS;
                cnt_d = '0;
                rd_d  = '0;
                err_d = 1'b0;
              end
            end
          end else begin
            out_eof_o = 1'b1;
            if (out_ready_i) begin
              st_d   = ST_HOLD;
              cnt_d  = '0;
              rd_d   = '0;
              err_d  = 1'b0;
              peof_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HOLD;
      cnt_q  <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
      peof_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      err_q  <= err_d;
      peof_q <= peof_d;
    end
  end

  assign buf_widx_o = IW'(cnt_q);
  assign buf_ridx_o = IW'(rd_q);
  assign st_o       = st_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/rx_short_frame_filter.sv
`timescale 1ns/1ps
module rx_short_frame_filter
  import sff_pkg::*;
#(
  parameter int DW     = 8,
  parameter int HOLD_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    proto_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_err_i,
  input  logic          in_eof_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_eof_o,
  input  logic          out_ready_i,
  output logic          drop_o
);
  localparam int DEPTH = HOLD_N + 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          use_in, buf_we;
  logic [IW-1:0] buf_widx, buf_ridx;
  logic [DW-1:0] buf_rd;
  sff_state_e    st;
  logic [CW-1:0] cnt;

  sff_ctrl #(.HOLD_N(HOLD_N)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .proto_i    (proto_i),
    .in_valid_i (in_valid_i),
    .in_err_i   (in_err_i),
    .in_eof_i   (in_eof_i),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_eof_o  (out_eof_o),
    .out_ready_i(out_ready_i),
    .drop_o     (drop_o),
    .use_in_o   (use_in),
    .buf_we_o   (buf_we),
    .buf_widx_o (buf_widx),
    .buf_ridx_o (buf_ridx),
    .st_o       (st),
    .cnt_o      (cnt)
  );

  sff_hold_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (buf_we),
    .wr_idx_i (buf_widx),
    .wr_data_i(in_data_i),
    .rd_idx_i (buf_ridx),
    .rd_data_o(buf_rd)
  );

  assign out_data_o = out_eof_o ? '0 : (use_in ? in_data_i : buf_rd);
endmodule

// File: rtl/sff_chk.sv
`timescale 1ns/1ps
module sff_chk
  import sff_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [1:0]    proto_i,
  input logic          in_valid_i,
  input logic          in_eof_i,
  input logic          in_ready_i,
  input logic          out_valid_i,
  input logic [DW-1:0] out_data_i,
  input logic          out_eof_i,
  input logic          out_ready_i,
  input logic          drop_i,
  input sff_state_e    st_i,
  input logic [CW-1:0] cnt_i
);
  AST_BYPASS_WIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_HOLD && cnt_i == '0 && !(en_i && proto_i <= 2'd1)) |-> (out_valid_i == in_valid_i)); // R2
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |-> !out_valid_i); // R3
  AST_DROP_ON_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |-> (en_i && in_valid_i && in_eof_i && in_ready_i)); // R3
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_HOLD && cnt_i != '0) |-> !out_valid_i); // R5
  AST_PASS_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PASS) |-> !drop_i); // R6
  AST_STALL_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |-> !in_ready_i); // R7
  AST_FLUSH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_FLUSH && out_valid_i && !out_ready_i) |=>
      (out_valid_i && $stable(out_data_i) && $stable(out_eof_i))); // R7
  AST_EOF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && out_eof_i) |-> (out_data_i == '0)); // R8
endmodule

bind rx_short_frame_filter sff_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .proto_i    (proto_i),
  .in_valid_i (in_valid_i),
  .in_eof_i   (in_eof_i),
  .in_ready_i (in_ready_o),
  .out_valid_i(out_valid_o),
  .out_data_i (out_data_o),
  .out_eof_i  (out_eof_o),
  .out_ready_i(out_ready_i),
  .drop_i     (drop_o),
  .st_i       (st),
  .cnt_i      (cnt)
);

// File: tb/rx_short_frame_filter_bench.sv
`timescale 1ns/1ps
module rx_short_frame_filter_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic [1:0]    proto_i = 2'd0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_err_i = 1'b0;
  logic          in_eof_i = 1'b0;
  logic          in_ready_o, out_valid_o, out_eof_o, drop_o;
  logic [DW-1:0] out_data_o;
  logic          out_ready_i = 1'b1;

  int checks = 0, fails = 0;
  int rmode = 0, cyc = 0;
  int acc = 0, got_drops = 0, early = 0, stall_bad = 0;
  bit eof_acc = 0, cur_filt = 0;
  logic [8:0] exp_q[$];
  logic [8:0] got_q[$];

  always #10 clk = ~clk;

  rx_short_frame_filter #(.DW(DW), .HOLD_N(2)) u_rx_short_frame_filter (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .proto_i(proto_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_err_i(in_err_i),
    .in_eof_i(in_eof_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_eof_o(out_eof_o), .out_ready_i(out_ready_i),
    .drop_o(drop_o)
  );

  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    case (rmode)
      0:       out_ready_i = 1'b1;
      1:       out_ready_i = cyc[0];
      default: out_ready_i = (cyc % 3 == 0);
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid_o && out_ready_i) begin
        got_q.push_back({out_eof_o, out_data_o});
        if (cur_filt && !out_eof_o && acc < 3 && !eof_acc) early = early + 1;
      end
      if (drop_o) got_drops = got_drops + 1;
      if (out_valid_o && !out_ready_i && in_ready_o) stall_bad = stall_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send_beat(input bit eof, input logic [DW-1:0] d, input bit err);
    bit r;
    in_valid_i = 1'b1;
    in_eof_i   = eof;
    in_data_i  = d;
    in_err_i   = err;
    forever begin
      @(negedge clk);
      r = in_ready_o;
      @(posedge clk);
      #2;
      if (r) break;
    end
    if (eof) eof_acc = 1;
    else     acc = acc + 1;
  endtask

  // errpos: -1 none, 0..len-1 that byte, len the end beat
  task automatic run_frame(input int fid, input bit en, input int proto, input int len,
                           input int errpos, input int rm);
    bit filt, supp;
    string tag;
    logic [DW-1:0] d;
    filt = en && (proto < 2);
    supp = filt && (len < 3) && (errpos >= 0);
    if (!filt)         tag = "R2";
    else if (supp)     tag = (len == 0) ? "R9" : "R3";
    else if (len == 0) tag = "R9";
    else if (len < 3)  tag = "R4";
    else if (errpos >= 0) tag = "R6";
    else               tag = "R5";
    exp_q.delete();
    got_q.delete();
    got_drops = 0; early = 0; stall_bad = 0; acc = 0; eof_acc = 0;
    en_i = en; proto_i = 2'(proto); rmode = rm; cur_filt = filt;
    for (int i = 0; i < len; i++) begin
      d = DW'(fid * 7 + i * 13 + 1);
      if (!supp) exp_q.push_back({1'b0, d});
    end
    if (!supp) exp_q.push_back(9'h100);
    for (int i = 0; i < len; i++) begin
      d = DW'(fid * 7 + i * 13 + 1);
      send_beat(1'b0, d, errpos == i);
    end
    send_beat(1'b1, DW'(8'hA5), errpos == len);
    in_valid_i = 1'b0; in_err_i = 1'b0; in_eof_i = 1'b0;
    repeat (12) @(posedge clk);
    #2;
    chk(got_q.size() == exp_q.size(), tag, "write count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        chk(got_q[i] == exp_q[i], exp_q[i][8] ? "R8" : tag, "write item",
            int'(got_q[i]), int'(exp_q[i]));
    chk(got_drops == (supp ? 1 : 0), supp ? tag : "R6", "drop pulses", got_drops, supp ? 1 : 0);
    if (filt) chk(early == 0, "R5", "writes before commit", early, 0);
    if (rm != 0) chk(stall_bad == 0, "R7", "input ready during stall", stall_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fid;
    fid = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid_o == 1'b0, "R1", "out_valid after reset", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R1", "in_ready after reset", in_ready_o, 1);
    chk(drop_o == 1'b0, "R1", "drop after reset", drop_o, 0);
    @(posedge clk);
    #2;
    for (int en = 0; en < 2; en++)
      for (int pr = 0; pr < 4; pr++)
        for (int len = 0; len < 6; len++)
          for (int ep = -1; ep <= len; ep++) begin
            run_frame(fid, en[0], pr, len, ep, fid % 3);
            fid = fid + 1;
          end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule